// File: doc/BRIEF.md
# Multi-width configuration data shifter

This block streams uncompressed configuration data to one or more downstream devices. It takes 16-bit words over a valid/ready handshake and sends them out on an 8-bit data bus, together with a generated configuration clock that runs at half the system clock. A mode input sets the bus width. In the serial modes, 1, 2, 4 or 8 lanes each drive their own serial chain, one bit per lane per clock. The byte-parallel mode places eight bits on the bus per clock.

The data source may be slower than the output. When no word is waiting, the output clock stays low and nothing is lost, so configuration simply stretches in time. A done input forces the idle pattern: the clock is held low and every data pin is driven high. This pattern also abandons any word that is partly sent.

Top module: `cfg_shifter`

## Requirements
- R1: After reset, `dclk_o` is low, `data_o` is 0, `bit_strobe_o` is low and `ready_o` is high.
- R2: `mode_i` selects the lane count n. The encodings are 0 for n=1, 1 for n=2, 2 for n=4 and 3 for n=8. The values 5, 6 and 7 act as n=1. A word is sent in 16/n slots. In slot s, pin k (k<n) carries word bit k+s*n, so the word goes out least significant bit first.
- R3: In byte-parallel mode (`mode_i`=4), the word is sent in two slots. The first slot carries bits 7:0 on `data_o[7:0]` and the second slot carries bits 15:8.
- R4: While a word is being sent, every pin of `data_o` at index n or above is low.
- R5: Each slot lasts two system cycles: one cycle with `dclk_o` low, then one cycle with `dclk_o` high. `data_o` changes only as `dclk_o` falls, so it is stable across each rising edge. `dclk_o` is never high for two cycles in a row.
- R6: `bit_strobe_o` is high exactly in the cycles where `dclk_o` is high, which gives one pulse per output rising edge.
- R7: `ready_o` is high only when the block is idle, or in the high phase of the last slot of a word. A word offered in that high phase starts on the next cycle, with no extra low cycle.
- R8: While no word is in progress and done is low, `dclk_o` stays low, `data_o` is 0 and `bit_strobe_o` is low.
- R9: The mode is captured when a word is accepted. Changes on `mode_i` while the word is being sent have no effect on that word.
- R10: While `done_i` is high, in the same cycle, `dclk_o` is low, `data_o` is all ones and `ready_o` is low. Any word in progress is dropped. After `done_i` falls, the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Width mode, sampled when a word is accepted |
| word_i | input | 16 | Configuration word |
| valid_i | input | 1 | Word is offered |
| ready_o | output | 1 | Word can be accepted this cycle |
| done_i | input | 1 | Configuration complete, forces the idle pattern |
| dclk_o | output | 1 | Generated configuration clock |
| data_o | output | 8 | Configuration data bus |
| bit_strobe_o | output | 1 | One pulse per output rising edge |

## Verification
Take the edge at which a word is accepted as edge E. Slot s of that word is shown with `dclk_o` low in the cycle after edge E+2s, and with `dclk_o` high in the cycle after edge E+2s+1. The bench samples at each falling system-clock edge in step with that count. Each slot is checked twice, once in its low phase and once in its high phase, and `ready_o` is checked at the final high phase so that chaining happens without a gap. The effect of `done_i` is combinational, so it is checked one time unit after the input changes. The pause state is checked on each cycle of an idle stretch.

// File: rtl/cfg_shifter_pkg.sv
package cfg_shifter_pkg;
  typedef enum logic [2:0] {
    MODE_X1   = 3'd0,
    MODE_X2   = 3'd1,
    MODE_X4   = 3'd2,
    MODE_X8   = 3'd3,
    MODE_BYTE = 3'd4
  } mode_e;

  // lanes driven per output clock for a mode
  function automatic int unsigned lanes_of(logic [2:0] m, int unsigned bus_w);
    case (m)
      MODE_X2:   lanes_of = 2;
      MODE_X4:   lanes_of = 4;
      MODE_X8:   lanes_of = 8;
      MODE_BYTE: lanes_of = bus_w;
      default:   lanes_of = 1;
    endcase
  endfunction
endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic done_i,
  output logic dclk_o,
  output logic fall_o,
  output logic strobe_o
);
  logic dclk_q, strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      dclk_q   <= (run_i && !done_i) ? ~dclk_q : 1'b0;
      strobe_q <= run_i && !done_i && !dclk_q;
    end
  end

  assign dclk_o   = dclk_q & ~done_i;
  assign strobe_o = strobe_q & ~done_i;
  // next system edge is an output falling edge
  assign fall_o   = dclk_q & ~done_i;
endmodule

// File: rtl/cfg_word_sreg.sv
module cfg_word_sreg
  import cfg_shifter_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              fall_i,
  input  logic              valid_i,
  input  logic [2:0]        mode_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic [2:0]        mode_o,
  output logic [WORD_W-1:0] sh_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic              busy_q;
  logic [2:0]        mode_q;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_slot, load;

  assign last_slot = (cnt_q == CNT_W'(1));
  assign ready_o   = !done_i && (!busy_q || (fall_i && last_slot));
  assign load      = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mode_q <= MODE_X1;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else if (done_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      mode_q <= mode_i;
      sh_q   <= word_i;
      cnt_q  <= CNT_W'(WORD_W / lanes_of(mode_i, BUS_W));
    end else if (busy_q && fall_i) begin
      sh_q  <= sh_q >> lanes_of(mode_q, BUS_W);
      cnt_q <= cnt_q - CNT_W'(1);
      if (last_slot) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign mode_o = mode_q;
  assign sh_o   = sh_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/cfg_lane_mux.sv
module cfg_lane_mux
  import cfg_shifter_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BUS_W  = 8
) (
  input  logic              done_i,
  input  logic              busy_i,
  input  logic [2:0]        mode_i,
  input  logic [WORD_W-1:0] sh_i,
  output logic [BUS_W-1:0]  data_o
);
  int unsigned lanes;
  assign lanes = lanes_of(mode_i, BUS_W);

  for (genvar k = 0; k < BUS_W; k++) begin : g_pin
    assign data_o[k] = done_i ? 1'b1 :
                       (busy_i && (k < lanes)) ? sh_i[k] : 1'b0;
  end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BUS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              done_i,
  output logic              dclk_o,
  output logic [BUS_W-1:0]  data_o,
  output logic              bit_strobe_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic              busy, fall;
  logic [2:0]        mode_q;
  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;

  cfg_clk_gen u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy),
    .done_i   (done_i),
    .dclk_o   (dclk_o),
    .fall_o   (fall),
    .strobe_o (bit_strobe_o)
  );

  cfg_word_sreg #(.WORD_W(WORD_W), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_sreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done_i),
    .fall_i  (fall),
    .valid_i (valid_i),
    .mode_i  (mode_i),
    .word_i  (word_i),
    .ready_o (ready_o),
    .busy_o  (busy),
    .mode_o  (mode_q),
    .sh_o    (sh),
    .cnt_o   (cnt)
  );

  cfg_lane_mux #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_mux (
    .done_i (done_i),
    .busy_i (busy),
    .mode_i (mode_q),
    .sh_i   (sh),
    .data_o (data_o)
  );
endmodule

// File: rtl/cfg_shifter_chk.sv
module cfg_shifter_chk
  import cfg_shifter_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_i,
  input logic             ready_o,
  input logic             dclk_o,
  input logic [BUS_W-1:0] data_o,
  input logic             bit_strobe_o,
  input logic             busy_i,
  input logic [2:0]       mode_i,
  input logic [CNT_W-1:0] cnt_i
);
  assert_unused_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i |-> (data_o >> lanes_of(mode_i, BUS_W)) == '0);

  assert_half_rate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_o |=> !dclk_o);

  assert_data_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_o |-> data_o == $past(data_o));

  assert_strobe_on_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dclk_o) |-> bit_strobe_o);

  assert_strobe_in_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_strobe_o |-> dclk_o);

  assert_ready_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && busy_i |-> dclk_o && cnt_i == CNT_W'(1));

  assert_pause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !done_i |-> !dclk_o && data_o == '0);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> data_o == '1 && !dclk_o && !ready_o);
endmodule

bind cfg_shifter cfg_shifter_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .done_i       (done_i),
  .ready_o      (ready_o),
  .dclk_o       (dclk_o),
  .data_o       (data_o),
  .bit_strobe_o (bit_strobe_o),
  .busy_i       (busy),
  .mode_i       (mode_q),
  .cnt_i        (cnt)
);

// File: tb/cfg_shifter_tb.sv
module cfg_shifter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [15:0] word_i = '0;
  logic        valid_i = 1'b0;
  logic        done_i = 1'b0;
  logic        ready_o, dclk_o, bit_strobe_o;
  logic [7:0]  data_o;

  int checks = 0;
  int failures = 0;
  bit preloaded = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_shifter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i), .word_i(word_i),
    .valid_i(valid_i), .ready_o(ready_o), .done_i(done_i),
    .dclk_o(dclk_o), .data_o(data_o), .bit_strobe_o(bit_strobe_o)
  );

  // {mode, word}
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 16'h8001}, {3'd1, 16'hB4E1}, {3'd2, 16'h1234}, {3'd3, 16'hF00D},
    {3'd4, 16'hC35A}, {3'd6, 16'h0F0F}, {3'd2, 16'hFFFF}, {3'd1, 16'h6A95}
  };

  function automatic int lanes(logic [2:0] m);
    case (m)
      3'd1: return 2;
      3'd2: return 4;
      3'd3, 3'd4: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_slot(logic [2:0] m, logic [15:0] w, int s);
    logic [7:0] r = '0;
    int n = lanes(m);
    for (int k = 0; k < n; k++) r[k] = w[k + s*n];
    return r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic play(input logic [2:0] m, input logic [15:0] w, input bit chain,
                      input logic [2:0] nm, input logic [15:0] nw);
    int n = lanes(m);
    int slots = 16 / n;
    string dtag = (m == 3'd4) ? "R3/R9" : "R2/R9";
    if (!preloaded) begin
      @(negedge clk);
      mode_i = m; word_i = w; valid_i = 1'b1;
      while (!ready_o) @(negedge clk);
    end
    @(posedge clk); #1;
    valid_i = 1'b0;
    mode_i = (m >= 3'd4) ? 3'd0 : m + 3'd1;  // R9: must not disturb this word
    word_i = ~w;
    preloaded = 1'b0;
    for (int s = 0; s < slots; s++) begin
      @(negedge clk);
      check("R5 low phase", 16'(dclk_o), 16'd0);
      check(dtag, 16'(data_o), 16'(exp_slot(m, w, s)));
      if (n < 8) check("R4 unused pins", 16'(data_o >> n), 16'd0);
      @(negedge clk);
      check("R5 high phase", 16'(dclk_o), 16'd1);
      check("R5 data hold", 16'(data_o), 16'(exp_slot(m, w, s)));
      check("R6 strobe", 16'(bit_strobe_o), 16'd1);
      if (s == slots - 1) begin
        check("R7 ready last slot", 16'(ready_o), 16'd1);
        if (chain) begin
          mode_i = nm; word_i = nw; valid_i = 1'b1; preloaded = 1'b1;
        end
      end else begin
        check("R7 ready busy", 16'(ready_o), 16'd0);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1;
    check("R1 dclk", 16'(dclk_o), 16'd0);
    check("R1 data", 16'(data_o), 16'd0);
    check("R1 strobe", 16'(bit_strobe_o), 16'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", 16'(ready_o), 16'd1);

    // table walk, back-to-back chaining (R7)
    for (int i = 0; i < 8; i++) begin
      play(VEC[i][18:16], VEC[i][15:0], i < 7,
           VEC[(i + 1) % 8][18:16], VEC[(i + 1) % 8][15:0]);
    end

    // R8: pause when no data
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R8 dclk held", 16'(dclk_o), 16'd0);
      check("R8 data low", 16'(data_o), 16'd0);
      check("R8 no strobe", 16'(bit_strobe_o), 16'd0);
      check("R8 ready", 16'(ready_o), 16'd1);
    end

    // R10: done forces idle pattern, offered word ignored
    @(negedge clk);
    done_i = 1'b1; valid_i = 1'b1; mode_i = 3'd3; word_i = 16'h1234;
    #1;
    check("R10 data ones", 16'(data_o), 16'h00FF);
    check("R10 dclk low", 16'(dclk_o), 16'd0);
    check("R10 ready low", 16'(ready_o), 16'd0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R10 held", 16'(data_o), 16'h00FF);
      check("R10 dclk held", 16'(dclk_o), 16'd0);
    end
    valid_i = 1'b0; done_i = 1'b0;
    #1;
    check("R10 release idle", 16'(data_o), 16'd0);
    check("R10 release ready", 16'(ready_o), 16'd1);

    // R10: done mid-word drops the word
    @(negedge clk);
    mode_i = 3'd0; word_i = 16'hFFFF; valid_i = 1'b1;
    @(posedge clk); #1;
    valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 pre-abort high", 16'(dclk_o), 16'd1);
    done_i = 1'b1;
    #1;
    check("R10 abort data", 16'(data_o), 16'h00FF);
    check("R10 abort dclk", 16'(dclk_o), 16'd0);
    @(negedge clk);
    done_i = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R10 word dropped data", 16'(data_o), 16'd0);
      check("R10 word dropped dclk", 16'(dclk_o), 16'd0);
    end

    // recovery after abort
    play(3'd1, 16'h5AA5, 1'b0, 3'd0, 16'h0);
    play(3'd4, 16'h81FE, 1'b0, 3'd0, 16'h0);
    finish_run();
  end
endmodule